// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This block is one execution slice of a vector engine. It holds a file of vector registers and runs one instruction at a time, one element per clock, starting at element 0. Its work is element-wise comparison, bitwise combination of boolean vectors, a scalar broadcast, and loading the per-element write-enable mask. A comparison writes a boolean vector into an ordinary vector register. Several such vectors are merged with a plain vector AND. A separate mask-load instruction then copies the merged vector into the mask register. No value passes through a scalar register on the way, and any later instruction flagged as masked uses that mask.

Instructions arrive on a valid/ready port: an opcode, a destination and two source register numbers, a 64-bit scalar immediate and a masked flag. The port takes an instruction only while the unit is idle. The sequencer has three states. IDLE has ready high and goes to EXEC when an instruction is accepted with a nonzero active length, or straight to FINISH when that length is zero or the opcode is set-length. EXEC handles one element per clock and goes to FINISH after the last active element. FINISH pulses done for one cycle and returns to IDLE. A combinational read-back port shows any element of any register.

Top module: `vmask_unit`

## Requirements
- R1: After reset, instr_ready is high, done is low, the vector length is 0, and every mask bit is 1, so a masked instruction writes every active element.
- R2: Opcode encoding on instr_op: 0 set-length, 1 broadcast, 2 not-equal vector/vector, 3 greater-than vector/vector, 4 not-equal vector/immediate, 5 greater-than vector/immediate, 6 AND, 7 mask-load. Set-length takes instr_imm[7:0] as the new length, and any value above NELEM (128) is stored as NELEM.
- R3: Broadcast writes instr_imm into elements 0 to length-1 of the destination. Elements at or above the length keep their old value.
- R4: The vector/vector compares write 1 where the relation holds and 0 where it does not. Greater-than treats both operands as signed 64-bit integers.
- R5: The vector/immediate compares apply the same relations against the full 64-bit immediate.
- R6: AND writes the bitwise AND of the two source elements.
- R7: Mask-load sets mask bit i to 1 when element i of the first source is nonzero and to 0 otherwise, for i below the length. Mask bits at or above the length are kept.
- R8: With instr_masked set, element i is written only where mask bit i is 1, and the other elements keep their value. Mask-load and set-length ignore the flag.
- R9: done goes high for exactly one cycle, length+1 clock edges after the accepting edge (1 edge for set-length). instr_ready is high again in the cycle after done.
- R10: With a length of 0, an instruction writes nothing and raises done after one edge.
- R11: The destination may be the same register as a source. Each result is computed from that source element's value before the instruction.
- R12: instr_valid asserted while the unit is busy is ignored, and no register changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Unit idle; instruction accepted when valid is also high |
| instr_op | input | 3 | Opcode (see R2) |
| instr_vd | input | 5 | Destination register number |
| instr_va | input | 5 | First source register number |
| instr_vb | input | 5 | Second source register number |
| instr_imm | input | 64 | Scalar immediate |
| instr_masked | input | 1 | Write only elements whose mask bit is set |
| done | output | 1 | One-cycle completion pulse |
| rd_reg | input | 5 | Read-back register number |
| rd_idx | input | 7 | Read-back element index |
| rd_data | output | 64 | Read-back element value |

## Verification
The two functions that share a cycle are the read of a source element and the write of the same element when the destination is that source register. The sequencer reads and writes element i in one clock. The bench provokes this with a not-equal compare against an immediate whose destination is its own source. It judges the result against values it computed from the register contents before the instruction. A second overlap, a new instruction arriving while one is executing, is provoked by holding instr_valid high through EXEC. It is judged by reading back the register the stray instruction targeted, which must be unchanged.

// File: rtl/vmask_pkg.sv
`timescale 1ns/1ps
package vmask_pkg;
    typedef enum logic [2:0] {
        OP_SETLEN   = 3'd0,
        OP_BCAST    = 3'd1,
        OP_NE_VV    = 3'd2,
        OP_GT_VV    = 3'd3,
        OP_NE_VI    = 3'd4,
        OP_GT_VI    = 3'd5,
        OP_AND      = 3'd6,
        OP_MASKLOAD = 3'd7
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vmask_seq.sv
`timescale 1ns/1ps
module vmask_seq
    import vmask_pkg::*;
#(
    parameter int NELEM = 128,
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    output logic          ready,
    output logic          running,
    output logic          done,
    output logic [IW-1:0] idx
);
    seq_state_e    state, state_n;
    logic [LW-1:0] len_q;
    logic          last;

    assign last = (LW'(idx) == len_q - LW'(1));

    // state register and element counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            len_q <= '0;
        end else begin
            state <= state_n;
            if (start) begin
                idx   <= '0;
                len_q <= start_len;
            end else if (state == ST_EXEC) begin
                idx <= idx + IW'(1);
            end
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = (start_len == '0) ? ST_FINISH : ST_EXEC;
            ST_EXEC:   if (last)  state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready   = (state == ST_IDLE);
        running = (state == ST_EXEC);
        done    = (state == ST_FINISH);
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idx_in_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (LW'(idx) < len_q));
    assert_exec_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (len_q != '0));
    assert_finish_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
endmodule

// File: rtl/vmask_alu.sv
`timescale 1ns/1ps
module vmask_alu
    import vmask_pkg::*;
#(
    parameter int EW = 64
) (
    input  vop_e          op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic [EW-1:0] imm,
    output logic [EW-1:0] res
);
    always_comb begin
        res = '0;
        unique case (op)
            OP_BCAST:    res = imm;
            OP_NE_VV:    res = EW'(a != b);
            OP_GT_VV:    res = EW'($signed(a) > $signed(b));
            OP_NE_VI:    res = EW'(a != imm);
            OP_GT_VI:    res = EW'($signed(a) > $signed(imm));
            OP_AND:      res = a & b;
            OP_SETLEN:   res = '0;
            OP_MASKLOAD: res = '0;
        endcase
    end
endmodule

// File: rtl/vmask_rf.sv
`timescale 1ns/1ps
module vmask_rf #(
    parameter int NREGS = 32,
    parameter int NELEM = 128,
    parameter int EW    = 64,
    localparam int RW = $clog2(NREGS),
    localparam int IW = $clog2(NELEM)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] w_reg,
    input  logic [IW-1:0] w_idx,
    input  logic [EW-1:0] w_data,
    input  logic [RW-1:0] a_reg,
    input  logic [IW-1:0] a_idx,
    output logic [EW-1:0] a_data,
    input  logic [RW-1:0] b_reg,
    input  logic [IW-1:0] b_idx,
    output logic [EW-1:0] b_data,
    input  logic [RW-1:0] c_reg,
    input  logic [IW-1:0] c_idx,
    output logic [EW-1:0] c_data
);
    logic [EW-1:0] mem [NREGS][NELEM];

    always_ff @(posedge clk) begin
        if (we) mem[w_reg][w_idx] <= w_data;
    end

    assign a_data = mem[a_reg][a_idx];
    assign b_data = mem[b_reg][b_idx];
    assign c_data = mem[c_reg][c_idx];
endmodule

// File: rtl/vmask_unit.sv
`timescale 1ns/1ps
module vmask_unit
    import vmask_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int NELEM = 128,
    parameter int EW    = 64,
    localparam int RW  = $clog2(NREGS),
    localparam int IW  = $clog2(NELEM),
    localparam int LW  = $clog2(NELEM + 1),
    localparam int VLW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    output logic          instr_ready,
    input  logic [2:0]    instr_op,
    input  logic [RW-1:0] instr_vd,
    input  logic [RW-1:0] instr_va,
    input  logic [RW-1:0] instr_vb,
    input  logic [EW-1:0] instr_imm,
    input  logic          instr_masked,
    output logic          done,
    input  logic [RW-1:0] rd_reg,
    input  logic [IW-1:0] rd_idx,
    output logic [EW-1:0] rd_data
);
    vop_e           op_in, op_q;
    logic [RW-1:0]  vd_q, va_q, vb_q;
    logic [EW-1:0]  imm_q;
    logic           masked_q;
    logic [VLW-1:0] vlen_q;
    logic [NELEM-1:0] lane_mask;
    logic           accept, running;
    logic [IW-1:0]  idx;
    logic [LW-1:0]  start_len;
    logic [EW-1:0]  a_data, b_data, res;
    logic           we;

    assign op_in     = vop_e'(instr_op);
    assign accept    = instr_valid && instr_ready;
    assign start_len = (op_in == OP_SETLEN) ? '0 : LW'(vlen_q);

    // instruction latch and length register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_SETLEN;
            vd_q     <= '0;
            va_q     <= '0;
            vb_q     <= '0;
            imm_q    <= '0;
            masked_q <= 1'b0;
            vlen_q   <= '0;
        end else if (accept) begin
            op_q     <= op_in;
            vd_q     <= instr_vd;
            va_q     <= instr_va;
            vb_q     <= instr_vb;
            imm_q    <= instr_imm;
            masked_q <= instr_masked;
            if (op_in == OP_SETLEN) begin
                if (instr_imm[VLW-1:0] > VLW'(NELEM)) vlen_q <= VLW'(NELEM);
                else                                  vlen_q <= instr_imm[VLW-1:0];
            end
        end
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)                              lane_mask      <= '1;
        else if (running && op_q == OP_MASKLOAD) lane_mask[idx] <= (a_data != '0);
    end

    assign we = running && (op_q != OP_MASKLOAD) && (!masked_q || lane_mask[idx]);

    vmask_seq #(.NELEM(NELEM)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_len (start_len),
        .ready     (instr_ready),
        .running   (running),
        .done      (done),
        .idx       (idx)
    );

    vmask_alu #(.EW(EW)) u_alu (
        .op  (op_q),
        .a   (a_data),
        .b   (b_data),
        .imm (imm_q),
        .res (res)
    );

    vmask_rf #(.NREGS(NREGS), .NELEM(NELEM), .EW(EW)) u_rf (
        .clk    (clk),
        .we     (we),
        .w_reg  (vd_q),
        .w_idx  (idx),
        .w_data (res),
        .a_reg  (va_q),
        .a_idx  (idx),
        .a_data (a_data),
        .b_reg  (vb_q),
        .b_idx  (idx),
        .b_data (b_data),
        .c_reg  (rd_reg),
        .c_idx  (rd_idx),
        .c_data (rd_data)
    );

    assert_vlen_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vlen_q <= VLW'(NELEM));
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && op_q == OP_MASKLOAD) |=> $stable(lane_mask));
    assert_len_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(vlen_q));
    assert_run_needs_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (vlen_q != '0));
endmodule

// File: tb/sim_vmask_unit.sv
`timescale 1ns/1ps
module sim_vmask_unit;
    localparam logic [2:0] C_SETLEN = 3'd0, C_BCAST = 3'd1, C_NE_VV = 3'd2, C_GT_VV = 3'd3,
                           C_NE_VI = 3'd4, C_GT_VI = 3'd5, C_AND = 3'd6, C_MLOAD = 3'd7;
    localparam int NE = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [2:0]  instr_op = '0;
    logic [4:0]  instr_vd = '0, instr_va = '0, instr_vb = '0;
    logic [63:0] instr_imm = '0;
    logic        instr_masked = 1'b0;
    logic        done;
    logic [4:0]  rd_reg = '0;
    logic [6:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [63:0]   mdl [32][NE];
    logic [NE-1:0] mmask;
    int            mvlen;

    always #4 clk = ~clk;

    vmask_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_vd(instr_vd), .instr_va(instr_va), .instr_vb(instr_vb),
        .instr_imm(instr_imm), .instr_masked(instr_masked), .done(done),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic report(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_apply(input logic [2:0] op, input int vd, input int va, input int vb,
                               input logic [63:0] imm, input bit m);
        int len = mvlen;
        if (op == C_SETLEN) begin
            mvlen = (imm[7:0] > 8'd128) ? 128 : int'(imm[7:0]);
        end else if (op == C_MLOAD) begin
            for (int i = 0; i < len; i++) mmask[i] = (mdl[va][i] != 64'd0);
        end else begin
            for (int i = 0; i < len; i++) begin
                logic [63:0] a = mdl[va][i];
                logic [63:0] b = mdl[vb][i];
                logic [63:0] r = 64'd0;
                case (op)
                    C_BCAST: r = imm;
                    C_NE_VV: r = {63'd0, a != b};
                    C_GT_VV: r = {63'd0, $signed(a) > $signed(b)};
                    C_NE_VI: r = {63'd0, a != imm};
                    C_GT_VI: r = {63'd0, $signed(a) > $signed(imm)};
                    C_AND:   r = a & b;
                    default: r = 64'd0;
                endcase
                if (!m || mmask[i]) mdl[vd][i] = r;
            end
        end
    endtask

    // issue one instruction, time its completion (R9), optionally hold valid high while busy (R12)
    task automatic issue(input logic [2:0] op, input int vd, input int va, input int vb,
                         input logic [63:0] imm, input bit m, input bit poke, input string req);
        int exp = (op == C_SETLEN) ? 1 : mvlen + 1;
        int n;
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_vd = 5'(vd); instr_va = 5'(va);
        instr_vb = 5'(vb); instr_imm = imm; instr_masked = m;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (poke && n < exp) begin
                instr_valid = 1'b1; instr_op = C_BCAST; instr_vd = 5'd7;
                instr_imm = 64'hDEAD_BEEF; instr_masked = 1'b0;
            end else begin
                instr_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        instr_valid = 1'b0;
        report(n == exp, {"R9 done latency ", req}, 64'(n), 64'(exp));
        model_apply(op, vd, va, vb, imm, m);
        @(negedge clk);
        report(!done && instr_ready, {"R9 done pulse/ready ", req}, {62'd0, done, instr_ready}, 64'd1);
    endtask

    task automatic check_reg(input int r, input string req);
        bit ok = 1;
        logic [63:0] act = 0, exp = 0;
        for (int i = 0; i < NE; i++) begin
            rd_reg = 5'(r); rd_idx = 7'(i);
            #1;
            if (ok && rd_data !== mdl[r][i]) begin
                ok = 0; act = rd_data; exp = mdl[r][i];
            end
        end
        report(ok, $sformatf("%s reg v%0d", req, r), act, exp);
    endtask

    task automatic t_reset_and_init();
        report(instr_ready === 1'b1 && done === 1'b0, "R1 ready/done after reset",
               {62'd0, instr_ready, done}, 64'd2);
        mvlen = 0;
        mmask = '1;
        issue(C_SETLEN, 0, 0, 0, 64'd128, 0, 0, "R2 setlen");
        for (int r = 0; r < 8; r++) issue(C_BCAST, r, 0, 0, 64'(r * 3), 1, 0, "R1 masked init");
        for (int r = 0; r < 8; r++) check_reg(r, "R1 mask all ones");
    endtask

    task automatic t_zero_len();
        issue(C_SETLEN, 0, 0, 0, 64'd0, 0, 0, "R10 len0");
        issue(C_BCAST, 1, 0, 0, 64'd99, 0, 0, "R10 len0 bcast");
        check_reg(1, "R10 no write");
    endtask

    task automatic t_clamp_prefix();
        issue(C_SETLEN, 0, 0, 0, 64'd200, 0, 0, "R2 clamp");
        issue(C_BCAST, 2, 0, 0, 64'h1234_5678_9ABC_DEF0, 0, 0, "R2 clamp bcast");
        check_reg(2, "R2 clamped length covers all");
        issue(C_SETLEN, 0, 0, 0, 64'd10, 0, 0, "R3 len10");
        issue(C_BCAST, 2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R3 prefix bcast");
        check_reg(2, "R3 prefix only");
    endtask

    task automatic t_compares();
        issue(C_SETLEN, 0, 0, 0, 64'd128, 0, 0, "R4 len128");
        issue(C_BCAST, 3, 0, 0, 64'd5, 0, 0, "R4 prep");
        issue(C_BCAST, 4, 0, 0, -64'sd3, 0, 0, "R4 prep");
        issue(C_SETLEN, 0, 0, 0, 64'd40, 0, 0, "R4 len40");
        issue(C_BCAST, 3, 0, 0, -64'sd3, 0, 0, "R4 prep");
        issue(C_SETLEN, 0, 0, 0, 64'd20, 0, 0, "R4 len20");
        issue(C_BCAST, 4, 0, 0, 64'd7, 0, 0, "R4 prep");
        issue(C_SETLEN, 0, 0, 0, 64'd128, 0, 0, "R4 len128");
        issue(C_NE_VV, 5, 3, 4, 64'd0, 0, 0, "R4 ne");
        check_reg(5, "R4 not-equal vv");
        issue(C_GT_VV, 6, 3, 4, 64'd0, 0, 0, "R4 gt");
        check_reg(6, "R4 signed greater vv");
        issue(C_GT_VI, 0, 3, 0, 64'd0, 0, 0, "R5 gt imm");
        check_reg(0, "R5 signed greater imm");
        issue(C_NE_VI, 1, 4, 0, -64'sd3, 0, 0, "R5 ne imm");
        check_reg(1, "R5 not-equal imm");
        issue(C_AND, 7, 5, 6, 64'd0, 0, 0, "R6 and");
        check_reg(7, "R6 and");
    endtask

    task automatic t_mask();
        issue(C_MLOAD, 0, 6, 0, 64'd0, 1, 0, "R7 mask load (flag ignored R8)");
        issue(C_BCAST, 2, 0, 0, 64'h55, 1, 0, "R8 masked bcast");
        check_reg(2, "R8 masked write");
        issue(C_GT_VV, 4, 3, 5, 64'd0, 1, 0, "R8 masked compare");
        check_reg(4, "R8 masked compare");
        issue(C_SETLEN, 0, 0, 0, 64'd8, 0, 0, "R7 len8");
        issue(C_BCAST, 0, 0, 0, 64'd0, 0, 0, "R7 prep");
        issue(C_MLOAD, 0, 0, 0, 64'd0, 0, 0, "R7 short mask load");
        issue(C_SETLEN, 0, 0, 0, 64'd128, 0, 0, "R7 len128");
        issue(C_BCAST, 1, 0, 0, 64'hAA, 1, 0, "R7 probe");
        check_reg(1, "R7 upper mask bits kept");
    endtask

    task automatic t_alias_and_busy();
        issue(C_MLOAD, 0, 3, 0, 64'd0, 0, 0, "R11 mask all set");
        issue(C_NE_VI, 3, 3, 0, 64'd5, 0, 1, "R11 self dest with busy poke");
        check_reg(3, "R11 self destination");
        check_reg(7, "R12 busy valid ignored");
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_200_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=complete");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_init();
        t_zero_len();
        t_clamp_prefix();
        t_compares();
        t_mask();
        t_alias_and_busy();
        finish_up();
    end
endmodule